// File: doc/BRIEF.md
# Per-Channel Averaging Sample Filter

This block sits between a shared ADC result stream and the per-channel result registers of a multi-channel sensor front end. Each incoming 12-bit sample carries a channel index. When averaging is switched on, the block keeps a separate running sum and sample count for each channel. After the programmed number of samples for a channel has arrived, it publishes their mean together with a one-cycle ready pulse on that channel's output bit.

When averaging is switched off, every sample is passed straight through one cycle after it arrives. A single 3-bit configuration word sets both the averaging switch and a depth code, and the depth is always a power of two. Writing the configuration word restarts all accumulation, so a new depth never mixes with samples collected under the old one.

Top module: `sample_avg_filter`

## Requirements
- R1: After reset, all bits of `rdy_o` are low and the filter is in pass-through mode (configuration word 0).
- R2: In pass-through mode (configuration bit 2 low), a valid sample on channel c sets bit c of `rdy_o` alone on the next cycle, and `data_o` equals the sample value.
- R3: Configuration bit 2 enables averaging, and bits [1:0] hold the depth code k, which selects a depth of 2^(k+1) samples. Word 0x5 averages 4 samples, 0x6 averages 8, 0x4 averages 2 and 0x7 averages 16. A written word takes effect on the following cycle.
- R4: In averaging mode, no ready pulse follows the first depth-1 samples of a channel. On the cycle after the depth-th sample, bit c of `rdy_o` pulses and `data_o` equals the sum of those samples shifted right by log2(depth), which truncates the fraction. Accumulation for that channel then restarts from zero.
- R5: Each channel has its own sum and count. Interleaving samples of different channels does not change any channel's result.
- R6: A configuration write clears every channel's sum and count. A sample presented in the same cycle as the write is discarded and produces no ready pulse.
- R7: A sample whose channel index is NUM_CH or higher is ignored: it produces no ready pulse and does not change any channel's sum or count.
- R8: At most one bit of `rdy_o` is set in any cycle, and a set bit only follows a cycle in which a valid sample arrived with no configuration write.
- R9: Sixteen full-scale samples (0xFFF) at depth code 3 yield 0xFFF, so the sum does not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3 | Configuration word: bit 2 enables averaging, bits [1:0] hold the depth code |
| smp_valid_i | input | 1 | Sample valid |
| smp_ch_i | input | 2 | Channel index of the sample |
| smp_data_i | input | 12 | Sample value |
| data_o | output | 12 | Averaged or passed-through value, meaningful while any bit of rdy_o is set |
| rdy_o | output | 3 | One-cycle ready pulse, one bit per channel |

## Verification
On every cycle, the assertions check the shape of the ready pulses: at most one bit is set, each set bit follows an accepted sample, no pulse follows a configuration write or an out-of-range channel index, and the pass-through value and channel are correct. The averaged values themselves can only be shown by the bench's scenarios. These cover each depth code, interleaved channels, a restart in the middle of a run, and full-scale input, all compared against a reference model of the per-channel sums.

// File: rtl/filt_pkg.sv
package filt_pkg;
  localparam int CODE_W    = 2;
  localparam int CFG_W     = CODE_W + 1;
  localparam int MAX_SHIFT = 2 ** CODE_W;
  localparam int CNT_W     = MAX_SHIFT;
  localparam int SH_W      = $clog2(MAX_SHIFT + 1);

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
  } filt_cfg_t;
endpackage

// File: rtl/filt_cfg_reg.sv
module filt_cfg_reg
  import filt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             en_o,
  output logic [SH_W-1:0]  shift_o,
  output logic [CNT_W-1:0] cnt_max_o
);
  filt_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= filt_cfg_t'(wdata_i);
  end

  assign en_o      = cfg_q.en;
  assign shift_o   = SH_W'(cfg_q.code) + SH_W'(1);
  // last count index = depth - 1
  assign cnt_max_o = {CNT_W{1'b1}} >> (SH_W'(CNT_W) - shift_o);
endmodule

// File: rtl/filt_chan_acc.sv
module filt_chan_acc
  import filt_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int ACC_W = DATA_W + MAX_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              hit_i,
  input  logic              en_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic [CNT_W-1:0]  cnt_max_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              fire_o,
  output logic [DATA_W-1:0] value_o
);
  logic [ACC_W-1:0] sum_q, total;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign total = sum_q + ACC_W'(data_i);
  assign last  = (cnt_q == cnt_max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (hit_i && en_i) begin
      if (last) begin
        sum_q <= '0;
        cnt_q <= '0;
      end else begin
        sum_q <= total;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fire_o  = hit_i && (!en_i || last);
  assign value_o = en_i ? DATA_W'(total >> shift_i) : data_i;
endmodule

// File: rtl/filt_out_stage.sv
module filt_out_stage #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CH-1:0]              fire_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  value_i,
  output logic [NUM_CH-1:0]              rdy_o,
  output logic [DATA_W-1:0]              data_o
);
  logic [DATA_W-1:0] sel;

  // fire_i is one-hot or zero, so an OR reduction selects
  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (fire_i[i]) sel = sel | value_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_o  <= '0;
      data_o <= '0;
    end else begin
      rdy_o <= fire_i;
      if (|fire_i) data_o <= sel;
    end
  end
endmodule

// File: rtl/sample_avg_filter.sv
module sample_avg_filter
  import filt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              smp_valid_i,
  input  logic [CH_W-1:0]   smp_ch_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [NUM_CH-1:0] rdy_o
);
  logic                          cfg_en;
  logic [SH_W-1:0]               shift;
  logic [CNT_W-1:0]              cnt_max;
  logic [NUM_CH-1:0]             fire;
  logic [NUM_CH-1:0][DATA_W-1:0] value;

  filt_cfg_reg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .en_o      (cfg_en),
    .shift_o   (shift),
    .cnt_max_o (cnt_max)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = smp_valid_i && !cfg_we_i && (smp_ch_i == CH_W'(g));

    filt_chan_acc #(.DATA_W(DATA_W)) u_acc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (cfg_we_i),
      .hit_i     (hit),
      .en_i      (cfg_en),
      .shift_i   (shift),
      .cnt_max_i (cnt_max),
      .data_i    (smp_data_i),
      .fire_o    (fire[g]),
      .value_o   (value[g])
    );
  end

  filt_out_stage #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .value_i (value),
    .rdy_o   (rdy_o),
    .data_o  (data_o)
  );
endmodule

// File: rtl/filt_checker.sv
module filt_checker #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 12,
  parameter int CH_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              en_i,
  input logic              smp_valid_i,
  input logic [CH_W-1:0]   smp_ch_i,
  input logic [DATA_W-1:0] smp_data_i,
  input logic [DATA_W-1:0] data_o,
  input logic [NUM_CH-1:0] rdy_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  AST_RDY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rdy_o)); // R8

  AST_RDY_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rdy_o) |-> ($past(smp_valid_i) && !$past(cfg_we_i))); // R8

  AST_CFG_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (rdy_o == '0)); // R6

  AST_BAD_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && (smp_ch_i > LAST_CH)) |=> (rdy_o == '0)); // R7

  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !cfg_we_i && !en_i && (smp_ch_i <= LAST_CH)) |=>
      ((rdy_o == (NUM_CH'(1) << $past(smp_ch_i))) && (data_o == $past(smp_data_i)))); // R2
endmodule

bind sample_avg_filter filt_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .en_i        (cfg_en),
  .smp_valid_i (smp_valid_i),
  .smp_ch_i    (smp_ch_i),
  .smp_data_i  (smp_data_i),
  .data_o      (data_o),
  .rdy_o       (rdy_o)
);

// File: tb/tb_sample_avg_filter.sv
`timescale 1ns/1ps
module tb_sample_avg_filter;
  localparam int NUM_CH = 3;
  localparam int DATA_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_wdata = '0;
  logic              smp_valid = 1'b0;
  logic [1:0]        smp_ch = '0;
  logic [DATA_W-1:0] smp_data = '0;
  logic [DATA_W-1:0] data_o;
  logic [NUM_CH-1:0] rdy_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  logic [2:0]  m_cfg = '0;
  int unsigned m_sum [NUM_CH];
  int unsigned m_cnt [NUM_CH];

  always #4 clk = ~clk;

  sample_avg_filter #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dut (
    .clk_i (clk), .rst_ni (rst_n), .cfg_we_i (cfg_we), .cfg_wdata_i (cfg_wdata),
    .smp_valid_i (smp_valid), .smp_ch_i (smp_ch), .smp_data_i (smp_data),
    .data_o (data_o), .rdy_o (rdy_o)
  );

  function automatic int unsigned depth_of(logic [2:0] c);
    return 32'd1 << (c[1:0] + 1);
  endfunction

  task automatic check(string tag, logic [NUM_CH-1:0] er, logic [DATA_W-1:0] ed);
    checks++;
    if (rdy_o !== er || (er != 0 && data_o !== ed)) begin
      failures++;
      $display("FAIL %s: rdy=%b data=%h expected rdy=%b data=%h", tag, rdy_o, data_o, er, ed);
    end
  endtask

  task automatic step(string tag, bit we, logic [2:0] wd, bit v, logic [1:0] ch, logic [DATA_W-1:0] d);
    logic [NUM_CH-1:0] er;
    logic [DATA_W-1:0] ed;
    er = '0; ed = '0;
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd; smp_valid = v; smp_ch = ch; smp_data = d;
    if (we) begin
      m_cfg = wd;
      for (int i = 0; i < NUM_CH; i++) begin m_sum[i] = 0; m_cnt[i] = 0; end
    end else if (v && ch < NUM_CH) begin
      if (!m_cfg[2]) begin
        er[ch] = 1'b1; ed = d;
      end else begin
        m_sum[ch] += d;
        m_cnt[ch]++;
        if (m_cnt[ch] == depth_of(m_cfg)) begin
          er[ch] = 1'b1;
          ed = DATA_W'(m_sum[ch] >> (m_cfg[1:0] + 1));
          m_sum[ch] = 0; m_cnt[ch] = 0;
        end
      end
    end
    @(posedge clk);
    #1;
    cfg_we = 1'b0; smp_valid = 1'b0;
    check(tag, er, ed);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_CH; i++) begin m_sum[i] = 0; m_cnt[i] = 0; end
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", '0, '0);
    @(negedge clk) rst_n = 1'b1;

    // R1/R2: pass-through after reset
    step("R2 bypass ch0", 0, 0, 1, 2'd0, 12'h123);
    step("R2 bypass ch2", 0, 0, 1, 2'd2, 12'hABC);
    step("R8 idle", 0, 0, 0, 2'd1, 12'h555);

    // R7: bad channel in both modes
    step("R7 bad ch bypass", 0, 0, 1, 2'd3, 12'hFFF);
    // R3: depth 4 (0x5)
    step("R6 cfg write 0x5", 1, 3'h5, 0, 2'd0, 0);
    step("R4 avg4 s1", 0, 0, 1, 2'd1, 12'd10);
    step("R7 bad ch avg", 0, 0, 1, 2'd3, 12'd900);
    step("R4 avg4 s2", 0, 0, 1, 2'd1, 12'd11);
    step("R4 avg4 s3", 0, 0, 1, 2'd1, 12'd12);
    step("R3 avg4 result", 0, 0, 1, 2'd1, 12'd14);   // 47>>2 = 11

    // R3: depth 8 (0x6), interleaved channels (R5)
    step("R6 cfg write 0x6", 1, 3'h6, 0, 2'd0, 0);
    for (int k = 0; k < 8; k++) begin
      step("R5 interleave ch0", 0, 0, 1, 2'd0, 12'(100 + k));
      step("R5 interleave ch2", 0, 0, 1, 2'd2, 12'(4000 - 7 * k));
    end

    // R6: mid-stream write clears sums; sample in write cycle dropped
    step("R3 cfg 0x4", 1, 3'h4, 0, 2'd0, 0);
    step("R4 avg2 s1", 0, 0, 1, 2'd0, 12'd7);
    step("R6 write with sample", 1, 3'h4, 1, 2'd0, 12'd999);
    step("R6 after clear s1", 0, 0, 1, 2'd0, 12'd3);
    step("R6 after clear result", 0, 0, 1, 2'd0, 12'd4);   // 7>>1 = 3

    // R9: full scale, depth 16
    step("R9 cfg 0x7", 1, 3'h7, 0, 2'd0, 0);
    for (int k = 0; k < 16; k++) step("R9 full scale", 0, 0, 1, 2'd1, 12'hFFF);

    // R2: return to bypass
    step("R2 cfg bypass", 1, 3'h3, 0, 2'd0, 0);
    step("R2 bypass ch1", 0, 0, 1, 2'd1, 12'h0F0);

    // constrained random mix (R8 and all modes)
    for (int n = 0; n < 3000; n++) begin
      bit we;
      we = ($urandom_range(99) < 2);
      step("R8 random", we, 3'($urandom_range(7)), ($urandom_range(3) != 0),
           2'($urandom_range(3)), 12'($urandom_range(4095)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule